// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block produces the card clock of an SD host from its base clock. Software programs a 16-bit control word that holds a divider code, an internal clock enable and a card clock enable. The block reports through a read-only flag when its internal clock has settled. The divider does not use a uniform ladder. It covers /1, /2, /3 and /4, and after that only powers of two up to /256.

Bring-up takes two writes. The first sets the internal enable and the divider code. Software then polls the stable flag. A second write with the same code adds the card enable. A card enable that arrives before the flag is set is dropped. The card clock is gated with a negative-edge gate that only moves while the divided clock is low. A running divider is reloaded with a new code only after the gate has closed. Because of this, no shortened high pulse ever reaches the card, whether software stops the clock or switches the divider.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the control read value is 0x0000 and the card clock is low.
- R2: Divider codes 1, 2, 4, 8, 16, 32, 64 and 128 (control bits [15:8]) divide the base clock by twice the code, from /2 up to /256.
- R3: Code 0 passes the base clock to the card clock unchanged.
- R4: Code 3 divides by 3, with one base cycle high and two low per period.
- R5: Any other code gives the next larger supported ratio: twice the code rounded up to a power of two, capped at /256. For example, 5 gives /16, 9 gives /32 and 200 gives /256.
- R6: Every even ratio is high for half of its period and low for the other half.
- R7: Reading back shows the code in bits [15:8], the internal enable in bit 0, the stable flag in bit 1 and the card enable in bit 2. All other bits read 0.
- R8: Once the internal enable is set from clear, the stable flag reads 1 exactly 16 base-clock cycles after the write edge and not earlier.
- R9: On the write edge that clears the internal enable or changes the code, the stable flag is cleared. A write that keeps the enable and the code leaves the flag set.
- R10: The card enable is stored only when the stable flag was already set and the same write keeps the internal enable and the code. Otherwise bit 2 reads 0 and the card clock stays low.
- R11: While the card enable is clear, the card clock is low. Writing 0x0000 clears the whole register and stops the card clock.
- R12: The card clock gate opens and closes only while the divided clock is low. A new code takes effect only while the gate is closed, so every high pulse on the card clock has its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word to write |
| ctrlRd | output | 16 | Current control word, including the stable flag |
| cardClk | output | 1 | Gated, divided card clock |

## Verification
The divider runs with every defined code, with code 3 and with several undefined codes. Each run counts high samples and rising edges over a 768-cycle window. The rising-edge count separates the ratios. The high count and the measured high-run length separate the 1-high/2-low pattern of /3 from the even half-duty patterns, and show that /1 passes the base clock through. A background monitor measures every complete high pulse to catch runts. It stays active while software stops the clock at each of eight phases of a /8 period, and while the code is changed under a running card clock. Register-level patterns check three cases: enabling the card in the same write as the internal enable, a rewrite with the same code, and a rewrite with a changed code. Together they tell apart a card enable that was accepted, dropped or cleared.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  localparam int CODE_W   = 8;
  localparam int CODE_LSB = 8;
  localparam int REG_W    = CODE_LSB + CODE_W;
  localparam int RATIO_W  = CODE_W + 1;
  localparam int EN_BIT   = 0;
  localparam int STB_BIT  = 1;
  localparam int CEN_BIT  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic              gateWant;
    logic [CODE_W-1:0] code;
  } divCtl_t;

  // Code to division ratio: 0 -> 1, 3 -> 3, otherwise 2*code rounded up to a
  // power of two and capped at 2**CODE_W.
  function automatic logic [RATIO_W-1:0] ratioOf(input logic [CODE_W-1:0] c);
    logic [RATIO_W:0] p;
    p = (RATIO_W+1)'(1);
    if (c == '0) return RATIO_W'(1);
    if (c == CODE_W'(3)) return RATIO_W'(3);
    for (int i = 0; i < CODE_W; i++)
      if (p < {2'b00, c}) p = p << 1;
    p = p << 1;
    if (p > (RATIO_W+1)'(1 << CODE_W)) p = (RATIO_W+1)'(1 << CODE_W);
    return p[RATIO_W-1:0];
  endfunction

  // Number of high base cycles per period
  function automatic logic [RATIO_W-1:0] hiLenOf(input logic [RATIO_W-1:0] r);
    if (r == RATIO_W'(3)) return RATIO_W'(1);
    return r >> 1;
  endfunction
endpackage

// File: rtl/sdclk_ctrl.sv
`timescale 1ns/1ps
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlRd,
  output divCtl_t          divCtl
);
  localparam int ST_W = $clog2(STABLE_CYCLES + 1);

  logic              intEnR, stableR, cardEnR;
  logic [CODE_W-1:0] codeR;
  logic [ST_W-1:0]   stCnt;

  logic [CODE_W-1:0] wrCode;
  logic              wrIntEn, wrCardEn, keepStable;
  logic              unusedWrBits;

  assign wrCode       = wrData[CODE_LSB +: CODE_W];
  assign wrIntEn      = wrData[EN_BIT];
  assign wrCardEn     = wrData[CEN_BIT];
  assign unusedWrBits = ^{wrData[STB_BIT], wrData[CODE_LSB-1:CEN_BIT+1]};

  // A write may keep the settled state only if nothing about the clock changes
  assign keepStable = wrIntEn && intEnR && stableR && (wrCode == codeR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnR  <= 1'b0;
      stableR <= 1'b0;
      cardEnR <= 1'b0;
      codeR   <= '0;
      stCnt   <= '0;
    end else if (wrEn) begin
      codeR   <= wrCode;
      intEnR  <= wrIntEn;
      stableR <= keepStable;
      cardEnR <= wrCardEn && keepStable;
      if (!keepStable) stCnt <= '0;
    end else if (intEnR && !stableR) begin
      if (stCnt == ST_W'(STABLE_CYCLES - 1)) stableR <= 1'b1;
      else                                   stCnt   <= stCnt + 1'b1;
    end
  end

  always_comb begin
    ctrlRd                     = '0;
    ctrlRd[CODE_LSB +: CODE_W] = codeR;
    ctrlRd[EN_BIT]             = intEnR;
    ctrlRd[STB_BIT]            = stableR;
    ctrlRd[CEN_BIT]            = cardEnR;
  end

  assign divCtl.run      = intEnR;
  assign divCtl.gateWant = cardEnR;
  assign divCtl.code     = codeR;

  // R9: a code change drops the stable flag on the write edge
  p_code_change_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrCode != codeR) |=> !stableR);

  // R10: a card enable can only appear once the clock had settled
  p_card_needs_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardEnR) |-> $past(stableR));

  // R11: an all-zero write empties the register
  p_zero_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrData == '0) |=> (ctrlRd == '0));

  // R8: stable only rises while the internal clock stays enabled
  p_stable_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stableR) |-> intEnR && $past(intEnR));
endmodule

// File: rtl/sdclk_div.sv
`timescale 1ns/1ps
module sdclk_div
  import sdclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    cardClk
);
  logic [CODE_W-1:0]  actCode;
  logic [RATIO_W-1:0] cnt, nxtCnt, actRatio, hiLen;
  logic               divHigh, gateQ, gateWant, bypass;

  assign actRatio = ratioOf(actCode);
  assign hiLen    = hiLenOf(actRatio);
  assign bypass   = (actRatio == RATIO_W'(1));
  assign nxtCnt   = (cnt == actRatio - 1'b1) ? '0 : cnt + 1'b1;

  // Reload or stop only while the gate is closed; otherwise keep counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCode <= '0;
      cnt     <= '0;
      divHigh <= 1'b0;
    end else if (!gateQ && (!ctl.run || (actCode != ctl.code))) begin
      actCode <= ctl.code;
      cnt     <= '0;
      divHigh <= 1'b0;
    end else begin
      cnt     <= nxtCnt;
      divHigh <= (nxtCnt < hiLen);
    end
  end

  assign gateWant = ctl.gateWant && ctl.run && (actCode == ctl.code);

  // Negative-edge gate: moves only while the clock it passes is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)                   gateQ <= 1'b0;
    else if (bypass || !divHigh) gateQ <= gateWant;
  end

  assign cardClk = bypass ? (clk & gateQ) : (divHigh & gateQ);

  // R12: the gate toggled only during a low phase of the divided clock
  p_gate_low_phase_r12: assert property (@(posedge clk) disable iff (!rstN)
    (gateQ != $past(gateQ)) && !bypass |-> !divHigh);

  // R12: the active code changes only with the gate closed
  p_reload_closed_r12: assert property (@(posedge clk) disable iff (!rstN)
    (actCode != $past(actCode)) |-> !$past(gateQ));

  // R2: the phase counter stays inside the active period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt < actRatio);
endmodule

// File: rtl/sd_clk_gen.sv
`timescale 1ns/1ps
module sd_clk_gen
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] ctrlRd,
  output logic        cardClk
);
  divCtl_t divCtl;

  sdclk_ctrl #(.STABLE_CYCLES(STABLE_CYCLES)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .ctrlRd (ctrlRd),
    .divCtl (divCtl)
  );

  sdclk_div i_div (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (divCtl),
    .cardClk (cardClk)
  );

  initial assert (REG_W == 16) else $error("control word must be 16 bits");
endmodule

// File: tb/test_sd_clk_gen.sv
`timescale 1ns/1ps
module test_sd_clk_gen;
  localparam int W = 768;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] ctrlRd;
  logic        cardClk;

  int nChk = 0;
  int nBad = 0;
  int monHi = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd_clk_gen i_sd_clk_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlRd(ctrlRd), .cardClk(cardClk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // R12 monitor: every complete high pulse must match the expected length
  initial begin
    int runLen;
    bit armed;
    runLen = 0; armed = 1'b0;
    forever begin
      @(posedge clk); #5;
      if (!rstN) begin
        armed = 1'b0; runLen = 0;
      end else if (cardClk) begin
        if (armed) runLen++;
      end else begin
        if (armed && runLen > 0 && monHi > 0)
          chk(runLen == monHi, "R12 pulse length", runLen, monHi);
        runLen = 0; armed = 1'b1;
      end
    end
  end

  task automatic measure(input int ratio, input string req);
    int hi, rises, expHi, expR;
    logic prevS, s;
    hi = 0; rises = 0;
    expHi = (ratio == 1) ? W : (ratio == 3) ? W / 3 : W / 2;
    expR  = (ratio == 1) ? 0 : W / ratio;
    @(posedge clk); #5; prevS = cardClk;
    for (int i = 0; i < W; i++) begin
      @(posedge clk); #5;
      s = cardClk;
      if (s) hi++;
      if (s && !prevS) rises++;
      prevS = s;
    end
    chk(rises == expR, {req, " edges"}, rises, expR);
    chk(hi == expHi, {req, " high time"}, hi, expHi);
  endtask

  task automatic lowFor(input int n, input string req);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if (cardClk) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  task automatic bringUp(input logic [7:0] code, input int ratio);
    doWrite(16'h0000);
    waitCyc(300);
    monHi = (ratio == 1) ? 0 : (ratio == 3) ? 1 : ratio / 2;
    doWrite({code, 8'h01});
    waitCyc(20);
    doWrite({code, 8'h05});
    chk(ctrlRd == {code, 8'h07}, "R7 readback running", ctrlRd, {code, 8'h07});
    waitCyc(600);
  endtask

  task automatic testReset();
    chk(ctrlRd == 16'h0000, "R1 ctrl after reset", ctrlRd, 0);
    lowFor(40, "R1 card clock after reset");
  endtask

  task automatic testStable();
    doWrite(16'h0201);
    chk(ctrlRd == 16'h0201, "R7 readback enable only", ctrlRd, 16'h0201);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 15) chk(ctrlRd[1] == 1'b0, "R8 not stable at 15", ctrlRd[1], 0);
      if (k == 16) chk(ctrlRd[1] == 1'b1, "R8 stable at 16", ctrlRd[1], 1);
    end
    doWrite(16'h0201);
    chk(ctrlRd == 16'h0203, "R9 same code keeps stable", ctrlRd, 16'h0203);
    doWrite(16'h0200);
    chk(ctrlRd == 16'h0200, "R9 enable clear drops stable", ctrlRd, 16'h0200);
  endtask

  task automatic testEarlyCard();
    doWrite(16'h0000);
    waitCyc(5);
    doWrite(16'h0105);
    chk(ctrlRd == 16'h0101, "R10 card enable with first write", ctrlRd, 16'h0101);
    waitCyc(30);
    chk(ctrlRd == 16'h0103, "R10 card still off once stable", ctrlRd, 16'h0103);
    lowFor(60, "R10 R11 no card clock");
  endtask

  task automatic testDefined();
    int codes[10]  = '{0, 1, 2, 3, 4, 8, 16, 32, 64, 128};
    int ratios[10] = '{1, 2, 4, 3, 8, 16, 32, 64, 128, 256};
    for (int i = 0; i < 10; i++) begin
      bringUp(codes[i][7:0], ratios[i]);
      if (ratios[i] == 1)      measure(1, "R3 pass-through");
      else if (ratios[i] == 3) measure(3, "R4 divide by three");
      else                     measure(ratios[i], "R2 R6 ratio");
    end
  endtask

  task automatic testUndefined();
    int codes[4]  = '{5, 6, 9, 200};
    int ratios[4] = '{16, 16, 32, 256};
    for (int i = 0; i < 4; i++) begin
      bringUp(codes[i][7:0], ratios[i]);
      measure(ratios[i], "R5 rounded ratio");
    end
  endtask

  task automatic testStopPhases();
    bringUp(8'h04, 8);
    for (int off = 0; off < 8; off++) begin
      doWrite(16'h0000);
      chk(ctrlRd == 16'h0000, "R11 zero write clears", ctrlRd, 0);
      waitCyc(12);
      lowFor(20, "R11 stopped after zero write");
      doWrite(16'h0401);
      waitCyc(20);
      doWrite(16'h0405);
      waitCyc(30 + off);
    end
    doWrite(16'h0401);
    chk(ctrlRd == 16'h0403, "R11 card off keeps stable", ctrlRd, 16'h0403);
    waitCyc(12);
    lowFor(40, "R11 card disable stops clock");
  endtask

  task automatic testSwitchRunning();
    bringUp(8'h04, 8);
    doWrite(16'h0805);
    chk(ctrlRd == 16'h0801, "R9 R10 code change drops card", ctrlRd, 16'h0801);
    waitCyc(12);
    lowFor(30, "R12 old clock drained");
    waitCyc(10);
    chk(ctrlRd == 16'h0803, "R8 restabilised", ctrlRd, 16'h0803);
    monHi = 8;
    doWrite(16'h0805);
    waitCyc(40);
    measure(16, "R12 after switch");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStable();
    testEarlyCard();
    testDefined();
    testUndefined();
    testStopPhases();
    testSwitchRunning();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule